// File: doc/BRIEF.md
# Compare and Auto-Reload Timer

This block is a word-addressed timer peripheral that watches a 64-bit free-running count supplied by an external system counter. In its normal mode it holds a 64-bit absolute compare value and raises its status once the count has reached that value. Software can also see and set the deadline as a signed 32-bit distance from the current count.

An auto-increment mode turns the block into a periodic tick source. When this mode starts, it sets a 64-bit target to the current count plus a 32-bit reload. Each time the count reaches the target, it sets a sticky event flag and moves the target to the count plus the reload again. While this mode is on, the compare logic has no effect on the status. Software clears the flag by writing 0 to it.

The interrupt output is a level signal. It is recomputed every cycle from the status and a mask bit. Access is by full 32-bit words over a simple valid/write bus. Read data is combinational, so it is valid in the same cycle as the request.

Top module: `cmp_reload_timer`

## Requirements
- R1: In normal mode (auto-increment enable 0) the timer condition is the unsigned comparison count >= compare over 64 bits. Compare is written at offset 0x20 (low word) and 0x24 (high word), and both words read back.
- R2: A read at offset 0x28 returns the low 32 bits of (compare - count).
- R3: A write of V at offset 0x28 sets compare to count plus V sign-extended to 64 bits, wrapping modulo 2^64.
- R4: Offset 0x10 (frequency) and offset 0x48 (reload) are plain 32-bit read/write registers.
- R5: At offset 0x2C, bit 0 is the enable and bit 1 is the mask, and only these two bits are writable. Bit 2 reads the status. The status is 0 while the enable is 0.
- R6: The interrupt output equals status AND NOT mask, and it follows the count within the same cycle.
- R7: At offset 0x4C, bit 0 is the auto-increment enable. The target (read-only, 0x40 low and 0x44 high) is loaded with count + reload (modulo 2^64) in two cases: when the auto-increment enable goes 0 to 1 while the main enable is 1, or when the main enable goes 0 to 1 while the auto-increment enable is 1.
- R8: While both enables are 1 and count >= target, the next clock edge sets the event flag (bit 1 of 0x4C) and reloads the target with count + reload. In this mode the status is the event flag, and the compare has no effect.
- R9: Writing 0 to bit 1 of 0x4C clears the event flag, and writing 1 leaves it unchanged. If a firing and a clear occur in the same cycle, the flag ends up set.
- R10: Offset 0x50 reads 1. The twelve words at 0xFD0 through 0xFFC read the bytes 04,00,00,00,B7,B0,0B,00,0D,F0,05,B1 in that order.
- R11: Writes to the read-only offsets (0x00, 0x04, 0x40, 0x44, 0x50 and the ID words) and to unmapped offsets change nothing. Reads of unmapped offsets return 0. Offsets 0x00 and 0x04 read the low and high words of the count.
- R12: After reset, frequency, control, compare, target, auto-increment control and reload are all 0, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Current system count |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that count_i is stable across each clock edge. They also assume that every access uses a word-aligned offset, and that the bus signals carry known values whenever bus_valid is high. The firing property relies on the count never moving backwards. The bench meets all of this: it changes the count and the bus signals only on the falling edge, it uses only aligned offsets, and it moves the count forward, or jumps it, only between accesses that it checks explicitly.

// File: rtl/cmp_reload_timer.sv
module cmp_reload_timer #(
  parameter int ADDR_W = 12,
  parameter logic [3:0] CFG_CODE = 4'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       count_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CNT_LO = 'h000, A_CNT_HI = 'h004, A_FREQ = 'h010,
    A_CMP_LO = 'h020, A_CMP_HI = 'h024, A_DELTA = 'h028, A_CTL = 'h02C,
    A_TGT_LO = 'h040, A_TGT_HI = 'h044, A_RELOAD = 'h048, A_AICTL = 'h04C,
    A_CFG = 'h050, A_ID_BASE = 'hFD0;

  logic [31:0] freq_q, reload_q;
  logic [63:0] cmp_q, tgt_q;
  logic        ctl_en, ctl_mask, ai_en, ai_flag;

  wire wr = bus_valid & bus_write;
  wire cmp_hit = count_i >= cmp_q;
  wire status = ctl_en & (ai_en ? ai_flag : cmp_hit);
  wire fire = ctl_en & ai_en & (count_i >= tgt_q);
  wire [63:0] next_tgt = count_i + {32'd0, reload_q};
  wire [31:0] delta_rd = cmp_q[31:0] - count_i[31:0];

  assign irq_o = status & ~ctl_mask;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0: id_byte = 8'h04;
      4'd4: id_byte = 8'hB7;
      4'd5: id_byte = 8'hB0;
      4'd6: id_byte = 8'h0B;
      4'd8: id_byte = 8'h0D;
      4'd9: id_byte = 8'hF0;
      4'd10: id_byte = 8'h05;
      4'd11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

  wire [ADDR_W-1:0] id_off = bus_addr - A_ID_BASE;
  wire id_sel = (bus_addr >= A_ID_BASE) && (bus_addr[1:0] == 2'b00);

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_valid && !bus_write) begin
      case (bus_addr)
        A_CNT_LO: bus_rdata = count_i[31:0];
        A_CNT_HI: bus_rdata = count_i[63:32];
        A_FREQ:   bus_rdata = freq_q;
        A_CMP_LO: bus_rdata = cmp_q[31:0];
        A_CMP_HI: bus_rdata = cmp_q[63:32];
        A_DELTA:  bus_rdata = delta_rd;
        A_CTL:    bus_rdata = {29'd0, status, ctl_mask, ctl_en};
        A_TGT_LO: bus_rdata = tgt_q[31:0];
        A_TGT_HI: bus_rdata = tgt_q[63:32];
        A_RELOAD: bus_rdata = reload_q;
        A_AICTL:  bus_rdata = {30'd0, ai_flag, ai_en};
        A_CFG:    bus_rdata = {28'd0, CFG_CODE};
        default:  if (id_sel) bus_rdata = {24'd0, id_byte(id_off[5:2])};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q <= '0; reload_q <= '0; cmp_q <= '0; tgt_q <= '0;
      ctl_en <= 1'b0; ctl_mask <= 1'b0; ai_en <= 1'b0; ai_flag <= 1'b0;
    end else begin
      if (wr) begin
        case (bus_addr)
          A_FREQ:   freq_q <= bus_wdata;
          A_RELOAD: reload_q <= bus_wdata;
          A_CMP_LO: cmp_q[31:0] <= bus_wdata;
          A_CMP_HI: cmp_q[63:32] <= bus_wdata;
          A_DELTA:  cmp_q <= count_i + {{32{bus_wdata[31]}}, bus_wdata};
          A_CTL: begin
            ctl_en <= bus_wdata[0];
            ctl_mask <= bus_wdata[1];
            if (!ctl_en && bus_wdata[0] && ai_en) tgt_q <= next_tgt;
          end
          A_AICTL: begin
            ai_en <= bus_wdata[0];
            if (!bus_wdata[1]) ai_flag <= 1'b0;
            if (!ai_en && bus_wdata[0] && ctl_en) tgt_q <= next_tgt;
          end
          default: ;
        endcase
      end
      if (fire) begin
        ai_flag <= 1'b1;
        tgt_q <= next_tgt;
      end
    end
  end
endmodule

// File: rtl/cmp_reload_timer_chk.sv
module cmp_reload_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] count_i,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq_o,
  input logic        ctl_en,
  input logic        ctl_mask,
  input logic        ai_en,
  input logic        ai_flag,
  input logic [63:0] cmp_q,
  input logic [63:0] tgt_q
);
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !irq_o);

  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mask |-> !irq_o);

  assert_compare_raises_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !ai_en && !ctl_mask && count_i >= cmp_q) |-> irq_o);

  assert_fire_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && ai_en && count_i >= tgt_q) |=> ai_flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ai_flag && !(bus_valid && bus_write && bus_addr == 12'h04C && !bus_wdata[1]))
      |=> ai_flag);

  assert_cfg_reads_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == 12'h050) |-> bus_rdata == 32'd1);
endmodule

bind cmp_reload_timer cmp_reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .count_i(count_i), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .ctl_en(ctl_en), .ctl_mask(ctl_mask),
  .ai_en(ai_en), .ai_flag(ai_flag), .cmp_q(cmp_q), .tgt_q(tgt_q)
);

// File: tb/tb_cmp_reload_timer.sv
module tb_cmp_reload_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [63:0] count_i = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmp_reload_timer dut (.clk(clk), .rst_n(rst_n), .count_i(count_i),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    bus_valid = 0;
  endtask

  task automatic irq_chk(string req, logic exp);
    @(negedge clk);
    #1 check(req, {31'd0, irq_o}, {31'd0, exp});
  endtask

  task automatic set_count(logic [63:0] c);
    @(negedge clk);
    count_i = c;
  endtask

  task automatic t_reset;
    rd_chk("R12", 12'h010, 0); rd_chk("R12", 12'h02C, 0);
    rd_chk("R12", 12'h020, 0); rd_chk("R12", 12'h024, 0);
    rd_chk("R12", 12'h040, 0); rd_chk("R12", 12'h048, 0);
    rd_chk("R12", 12'h04C, 0); irq_chk("R12", 0);
  endtask

  task automatic t_plain_regs;
    wr(12'h010, 32'h0123_4567); rd_chk("R4", 12'h010, 32'h0123_4567);
    wr(12'h048, 32'hCAFE_0001); rd_chk("R4", 12'h048, 32'hCAFE_0001);
    wr(12'h048, 0);
  endtask

  task automatic t_compare;
    set_count(64'd100);
    wr(12'h020, 200); wr(12'h024, 0);
    rd_chk("R1", 12'h020, 200);
    wr(12'h02C, 32'hFFFF_FFF1);
    rd_chk("R5", 12'h02C, 1); irq_chk("R6", 0);
    set_count(64'd200);
    rd_chk("R1", 12'h02C, 5); irq_chk("R6", 1);
    set_count(64'd199);
    rd_chk("R1", 12'h02C, 1);
    wr(12'h024, 32'h8000_0000);
    set_count(64'h0000_0001_FFFF_FFFF);
    rd_chk("R1 unsigned", 12'h02C, 1);
    set_count(64'hFFFF_FFFF_0000_0000);
    rd_chk("R1 unsigned", 12'h02C, 5);
    wr(12'h02C, 3);
    rd_chk("R6", 12'h02C, 7); irq_chk("R6 masked", 0);
    wr(12'h02C, 0);
    rd_chk("R5 disabled", 12'h02C, 0); irq_chk("R5", 0);
  endtask

  task automatic t_delta;
    wr(12'h020, 32'h10); wr(12'h024, 0);
    set_count(64'h20);
    rd_chk("R2", 12'h028, 32'hFFFF_FFF0);
    set_count(64'h1_0000_0005);
    wr(12'h028, 32'hFFFF_FFFE);
    rd_chk("R3", 12'h020, 3); rd_chk("R3", 12'h024, 1);
    set_count(64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h028, 2);
    rd_chk("R3 wrap", 12'h020, 1); rd_chk("R3 wrap", 12'h024, 0);
  endtask

  task automatic t_autoinc;
    wr(12'h020, 1); wr(12'h024, 0);
    wr(12'h048, 10);
    set_count(64'd1000);
    wr(12'h02C, 1);
    wr(12'h04C, 1);
    rd_chk("R7", 12'h040, 1010); rd_chk("R7", 12'h044, 0);
    set_count(64'd1005);
    rd_chk("R8", 12'h04C, 1); irq_chk("R8 compare ignored", 0);
    set_count(64'd1010);
    @(negedge clk);
    rd_chk("R8", 12'h04C, 3); rd_chk("R8", 12'h040, 1020);
    rd_chk("R8", 12'h02C, 5); irq_chk("R8", 1);
    wr(12'h04C, 3); rd_chk("R9 keep", 12'h04C, 3);
    wr(12'h04C, 1); rd_chk("R9 clear", 12'h04C, 1); irq_chk("R9", 0);
    @(negedge clk);
    count_i = 64'd1020;
    bus_valid = 1; bus_write = 1; bus_addr = 12'h04C; bus_wdata = 1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    rd_chk("R9 set wins", 12'h04C, 3); rd_chk("R8", 12'h040, 1030);
    wr(12'h02C, 0); wr(12'h04C, 1);
    set_count(64'd5000);
    wr(12'h02C, 1);
    rd_chk("R7 main enable", 12'h040, 5010);
    rd_chk("R7", 12'h04C, 1); irq_chk("R7", 0);
    wr(12'h02C, 0); rd_chk("R5", 12'h02C, 0);
  endtask

  task automatic t_ids;
    logic [7:0] ids [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'hB7, 8'hB0,
                             8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    rd_chk("R10", 12'h050, 1);
    for (int i = 0; i < 12; i++)
      rd_chk("R10 id", 12'hFD0 + 12'(4 * i), {24'd0, ids[i]});
  endtask

  task automatic t_readonly;
    set_count(64'h0000_00AB_0000_00CD);
    rd_chk("R11 count lo", 12'h000, 32'hCD);
    rd_chk("R11 count hi", 12'h004, 32'hAB);
    wr(12'h000, 32'hDEAD); wr(12'h040, 32'hDEAD); wr(12'h044, 32'hDEAD);
    wr(12'h050, 0); wr(12'hFE0, 0); wr(12'h030, 32'h1234); wr(12'h100, 32'h5678);
    rd_chk("R11", 12'h000, 32'hCD);
    rd_chk("R11", 12'h040, 5010); rd_chk("R11", 12'h044, 0);
    rd_chk("R11", 12'h050, 1); rd_chk("R11", 12'hFE0, 32'hB7);
    rd_chk("R11 unmapped", 12'h030, 0); rd_chk("R11 unmapped", 12'h100, 0);
    rd_chk("R11", 12'h010, 32'h0123_4567); rd_chk("R11", 12'h048, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_plain_regs();
    t_compare();
    t_delta();
    t_autoinc();
    t_ids();
    t_readonly();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule